// File: doc/BRIEF.md
# Manual Serial Bit-Operation Sequencer

This block lets software take the serial link to a power-management chip away from the automatic command engine and drive it one primitive at a time. When both the mux-select control and the manual-enable control are 1, the block owns the chip-select, clock and data pins. Otherwise those pins pass straight through from the automatic engine.

Each write of a command word places one primitive in a small queue. A primitive is chip-select low, chip-select high, or shift-out of a single data bit with one clock pulse. The primitives run strictly in the order they were written. A busy flag stays up until the queue is empty and the current primitive has finished.

A typical use is resetting the slave. Software first clears the wrapper enable, the arbitration enable and the dual-IO mode elsewhere. It then sends chip-select low, one shift-out and chip-select high, followed by four more shift-outs while chip-select stays high, so the slave sees extra clocks.

Top module: `bitop_seq_top`

## Requirements
- R1: After reset, chip-select is high (1), the clock is low (0), busy is 0 and the error flag is 0.
- R2: Manual mode is active only when `mux_sel` and `man_en` are both 1. In every other case `spi_csn`, `spi_sck` and `spi_mosi` equal `eng_csn`, `eng_sck` and `eng_mosi`.
- R3: Command word layout: bit 13 is the write flag and must be 1, and bits 12:8 hold the operation code. Code 5'h08 drives chip-select low, 5'h09 drives chip-select high, and 5'h04 shifts out bit 0 of the word.
- R4: Primitives run in write order. The queue holds 4 words and the primitive in execution is held separately. A write that arrives while the queue is full is ignored.
- R5: A shift-out drives the data bit and then holds the clock high for H cycles and low for H cycles, where H is `half_period`, or 1 when `half_period` is 0. The data line does not change while the clock is high.
- R6: `busy` is 1 whenever a word is queued or a primitive is executing, and 0 otherwise.
- R7: A word with an unknown operation code, or with bit 13 cleared, is dropped without touching any pin. It sets `err`, which stays 1 until `err_clr` is pulsed.
- R8: Command writes made while manual mode is inactive are ignored. Leaving manual mode flushes the queue, aborts the primitive in progress, returns chip-select high and the clock low, and drops busy on the next cycle.
- R9: The slave-reset sequence (chip-select low, one shift, chip-select high, four shifts) produces those pin events in that order, and chip-select is high during the last four clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_sel | input | 1 | Pin-ownership select; 1 selects the manual path |
| man_en | input | 1 | Manual-mode enable |
| cmd_valid | input | 1 | One-cycle strobe that writes `cmd_word` |
| cmd_word | input | 16 | Manual command word |
| half_period | input | 8 | Clock phase length in cycles |
| err_clr | input | 1 | Clears the sticky error flag |
| eng_csn | input | 1 | Chip-select from the automatic engine |
| eng_sck | input | 1 | Clock from the automatic engine |
| eng_mosi | input | 1 | Data from the automatic engine |
| spi_csn | output | 1 | Chip-select pin to the slave |
| spi_sck | output | 1 | Clock pin to the slave |
| spi_mosi | output | 1 | Data pin to the slave |
| busy | output | 1 | Primitive queued or executing |
| err | output | 1 | Sticky bad-command flag |

## Verification
The assertions assume that `half_period` is held constant while a shift-out is in progress, and that `mux_sel` and `man_en` change only between command bursts. The stimulus follows both rules: it waits for busy to fall before it changes the phase length, and it changes mode mid-operation only in the dedicated abort scenario. The pin monitor is paused for that scenario, because the clock pulse there is cut short on purpose. The bench never issues chip-select low while chip-select is already low, so every written primitive produces exactly one observable pin edge.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int CMD_W   = 16;
  localparam int RW_BIT  = 13;
  localparam int OP_LSB  = 8;
  localparam int OP_W    = 5;

  localparam logic [OP_W-1:0] OP_CS_LOW  = 5'h08;
  localparam logic [OP_W-1:0] OP_CS_HIGH = 5'h09;
  localparam logic [OP_W-1:0] OP_SHIFT   = 5'h04;

  typedef enum logic [1:0] {
    PRIM_BAD = 2'd0,
    PRIM_CSL = 2'd1,
    PRIM_CSH = 2'd2,
    PRIM_BIT = 2'd3
  } prim_kind_e;

  typedef struct packed {
    prim_kind_e kind;
    logic       bit_val;
  } prim_t;

  // Turns a raw command word into a primitive; anything unrecognised is PRIM_BAD.
  function automatic prim_t decode_cmd(input logic [CMD_W-1:0] w);
    prim_t p;
    logic [OP_W-1:0] op;
    op        = w[OP_LSB +: OP_W];
    p.bit_val = w[0];
    p.kind    = PRIM_BAD;
    if (w[RW_BIT]) begin
      case (op)
        OP_CS_LOW:  p.kind = PRIM_CSL;
        OP_CS_HIGH: p.kind = PRIM_CSH;
        OP_SHIFT:   p.kind = PRIM_BIT;
        default:    p.kind = PRIM_BAD;
      endcase
    end
    return p;
  endfunction

  // Phase length in cycles: a programmed zero counts as one.
  function automatic logic [15:0] eff_half(input logic [15:0] h);
    return (h == 16'd0) ? 16'd1 : h;
  endfunction

endpackage

// File: rtl/bitop_fifo.sv
module bitop_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_MAX);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wr_ptr == PW'(i)) mem[i] <= din;
    end
  end

endmodule

// File: rtl/bitop_engine.sv
module bitop_engine
  import bitop_pkg::*;
#(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  prim_t         prim,
  input  logic [HW-1:0] half_period,
  input  logic          err_clr,
  output logic          csn,
  output logic          sck,
  output logic          mosi,
  output logic          active,
  output logic          err
);
  typedef enum logic [1:0] {ST_IDLE, ST_HIGH, ST_LOW} st_e;

  st_e           st;
  logic [HW-1:0] cnt;
  logic [HW-1:0] reload;

  assign reload = HW'(eff_half(16'(half_period)));
  assign active = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      csn  <= 1'b1;
      sck  <= 1'b0;
      mosi <= 1'b0;
      err  <= 1'b0;
    end else if (abort) begin
      st  <= ST_IDLE;
      cnt <= '0;
      csn <= 1'b1;
      sck <= 1'b0;
    end else begin
      if (err_clr) err <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            case (prim.kind)
              PRIM_CSL: csn <= 1'b0;
              PRIM_CSH: csn <= 1'b1;
              PRIM_BIT: begin
                mosi <= prim.bit_val;
                sck  <= 1'b1;
                cnt  <= reload;
                st   <= ST_HIGH;
              end
              default: err <= 1'b1;
            endcase
          end
        end
        ST_HIGH: begin
          if (cnt <= 1) begin
            sck <= 1'b0;
            cnt <= reload;
            st  <= ST_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_LOW: begin
          if (cnt <= 1) st <= ST_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitop_pinmux.sv
module bitop_pinmux (
  input  logic manual,
  input  logic man_csn,
  input  logic man_sck,
  input  logic man_mosi,
  input  logic eng_csn,
  input  logic eng_sck,
  input  logic eng_mosi,
  output logic spi_csn,
  output logic spi_sck,
  output logic spi_mosi
);
  always_comb begin
    if (manual) begin
      spi_csn  = man_csn;
      spi_sck  = man_sck;
      spi_mosi = man_mosi;
    end else begin
      spi_csn  = eng_csn;
      spi_sck  = eng_sck;
      spi_mosi = eng_mosi;
    end
  end
endmodule

// File: rtl/bitop_seq_top.sv
module bitop_seq_top
  import bitop_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int HW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_sel,
  input  logic              man_en,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [HW-1:0]     half_period,
  input  logic              err_clr,
  input  logic              eng_csn,
  input  logic              eng_sck,
  input  logic              eng_mosi,
  output logic              spi_csn,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              busy,
  output logic              err
);
  logic             manual;
  logic             push, pop;
  logic             q_empty, q_full;
  logic [CMD_W-1:0] q_word;
  prim_t            prim;
  logic             exec_active;
  logic             man_csn, man_sck, man_mosi;

  assign manual = mux_sel && man_en;
  assign push   = cmd_valid && manual && !q_full;
  assign pop    = manual && !q_empty && !exec_active;
  assign prim   = decode_cmd(q_word);
  assign busy   = !q_empty || exec_active;

  bitop_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!manual),
    .push  (push),
    .din   (cmd_word),
    .pop   (pop),
    .dout  (q_word),
    .empty (q_empty),
    .full  (q_full)
  );

  bitop_engine #(.HW(HW)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort       (!manual),
    .start       (pop),
    .prim        (prim),
    .half_period (half_period),
    .err_clr     (err_clr),
    .csn         (man_csn),
    .sck         (man_sck),
    .mosi        (man_mosi),
    .active      (exec_active),
    .err         (err)
  );

  bitop_pinmux u_mux (
    .manual   (manual),
    .man_csn  (man_csn),
    .man_sck  (man_sck),
    .man_mosi (man_mosi),
    .eng_csn  (eng_csn),
    .eng_sck  (eng_sck),
    .eng_mosi (eng_mosi),
    .spi_csn  (spi_csn),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
  );

endmodule

// File: rtl/bitop_seq_chk.sv
module bitop_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic manual,
  input logic push,
  input logic pop,
  input logic man_csn,
  input logic man_sck,
  input logic man_mosi,
  input logic busy,
  input logic err,
  input logic err_clr
);
  // R3: chip-select moves only when a primitive is taken from the queue
  p_cs_on_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && !pop) |=> $stable(man_csn));

  // R5: data held while the clock is high
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (man_sck && $past(man_sck)) |-> $stable(man_mosi));

  // R6: an accepted write makes the block busy
  p_busy_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> busy);

  // R7: error flag is sticky until cleared
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

  // R8: leaving manual mode empties the block
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual) |=> (!busy && man_csn && !man_sck));
endmodule

bind bitop_seq_top bitop_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .manual   (manual),
  .push     (push),
  .pop      (pop),
  .man_csn  (man_csn),
  .man_sck  (man_sck),
  .man_mosi (man_mosi),
  .busy     (busy),
  .err      (err),
  .err_clr  (err_clr)
);

// File: tb/tb_bitop_seq_top.sv
module tb_bitop_seq_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mux_sel = 0, man_en = 0, cmd_valid = 0, err_clr = 0;
  logic [15:0] cmd_word = 0;
  logic [7:0]  half_period = 8'd3;
  logic        eng_csn = 1, eng_sck = 0, eng_mosi = 0;
  logic        spi_csn, spi_sck, spi_mosi, busy, err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  bitop_seq_top dut (.*);

  // Scoreboard: 8'h10 cs fell, 8'h11 cs rose, 8'h2x clock pulse with x = {csn, bit}
  logic [7:0] exp_q[$];
  bit   mon_en = 0;
  logic prev_csn = 1, prev_sck = 0;
  int   hi_cnt = 0;
  int   exp_half = 3;
  bit   exp_csn = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic got(input logic [7:0] ev);
    if (exp_q.size() == 0) chk(0, "R4 unexpected pin event", ev, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(ev == e, "R4/R9 event order", ev, e);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_csn && !spi_csn) got(8'h10);
      if (!prev_csn && spi_csn) got(8'h11);
      if (!prev_sck && spi_sck) begin
        got(8'h20 | {6'd0, spi_csn, spi_mosi});
        hi_cnt = 1;
      end else if (spi_sck) hi_cnt++;
      if (prev_sck && !spi_sck) chk(hi_cnt == exp_half, "R5 clock high length", hi_cnt, exp_half);
    end
    prev_csn = spi_csn;
    prev_sck = spi_sck;
  end

  function automatic logic [15:0] mk(input bit rw, input logic [4:0] op, input bit b);
    return {2'b00, rw, op, 7'd0, b};
  endfunction

  // driver: writes the word and records the pin event it should cause
  task automatic send(input logic [15:0] w, input bit expect_ev);
    @(negedge clk);
    cmd_valid = 1; cmd_word = w;
    if (expect_ev) begin
      case (w[12:8])
        5'h08: begin exp_q.push_back(8'h10); exp_csn = 0; end
        5'h09: begin exp_q.push_back(8'h11); exp_csn = 1; end
        5'h04: exp_q.push_back(8'h20 | {6'd0, exp_csn, w[0]});
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mux_sel = 1; man_en = 1;
    #1;
    // R1 reset state
    chk(spi_csn == 1, "R1 csn", spi_csn, 1);
    chk(spi_sck == 0, "R1 sck", spi_sck, 0);
    chk(busy == 0,    "R1 busy", busy, 0);
    chk(err == 0,     "R1 err", err, 0);

    // R2 pass-through when not fully in manual mode
    for (int m = 0; m < 3; m++) begin
      mux_sel = (m == 1); man_en = (m == 2);
      for (int p = 0; p < 8; p++) begin
        eng_csn = p[0]; eng_sck = p[1]; eng_mosi = p[2];
        #1;
        chk({spi_csn, spi_sck, spi_mosi} == {eng_csn, eng_sck, eng_mosi}, "R2 pass-through",
            {spi_csn, spi_sck, spi_mosi}, {eng_csn, eng_sck, eng_mosi});
      end
    end
    eng_csn = 1; eng_sck = 0; eng_mosi = 0;
    @(negedge clk);
    mux_sel = 1; man_en = 1;
    @(negedge clk);
    prev_csn = spi_csn; prev_sck = spi_sck;
    mon_en = 1;

    // R9 slave-reset sequence, R3 codes
    half_period = 8'd3; exp_half = 3;
    send(mk(1, 5'h08, 0), 1);
    send(mk(1, 5'h04, 1), 1);
    send(mk(1, 5'h09, 0), 1);
    send(mk(1, 5'h04, 0), 1);
    send(mk(1, 5'h04, 1), 1);
    send(mk(1, 5'h04, 0), 1);
    send(mk(1, 5'h04, 1), 1);
    chk(busy == 1, "R6 busy while working", busy, 1);
    wait_idle();
    chk(busy == 0, "R6 idle after sequence", busy, 0);
    chk(spi_csn == 1, "R9 csn high after reset sequence", spi_csn, 1);
    chk(exp_q.size() == 0, "R9 all events seen", exp_q.size(), 0);

    // R5 zero phase length counts as one
    half_period = 8'd0; exp_half = 1;
    send(mk(1, 5'h08, 0), 1);
    send(mk(1, 5'h04, 1), 1);
    send(mk(1, 5'h04, 0), 1);
    send(mk(1, 5'h09, 0), 1);
    wait_idle();
    chk(exp_q.size() == 0, "R5 zero phase events", exp_q.size(), 0);

    // R4 back-to-back burst: one executes, four queue, sixth dropped
    half_period = 8'd6; exp_half = 6;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      cmd_valid = 1; cmd_word = mk(1, 5'h04, i[0]);
      if (i < 5) exp_q.push_back(8'h20 | {6'd0, 1'b1, i[0]});
      @(negedge clk);
    end
    cmd_valid = 0;
    chk(busy == 1, "R6 busy during burst", busy, 1);
    wait_idle();
    chk(exp_q.size() == 0, "R4 burst events", exp_q.size(), 0);

    // R7 unknown code and cleared write flag
    half_period = 8'd2; exp_half = 2;
    send(mk(1, 5'h1F, 1), 0);
    wait_idle();
    chk(err == 1, "R7 unknown code sets err", err, 1);
    chk(spi_csn == 1 && spi_sck == 0, "R7 pins untouched", {spi_csn, spi_sck}, 2);
    repeat (3) @(negedge clk);
    chk(err == 1, "R7 err sticky", err, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(err == 0, "R7 err cleared", err, 0);
    send(mk(0, 5'h04, 1), 0);
    wait_idle();
    chk(err == 1, "R7 clear write flag sets err", err, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;

    // R8 writes outside manual mode ignored
    man_en = 0;
    send(mk(1, 5'h08, 0), 0);
    man_en = 1;
    repeat (5) @(negedge clk);
    chk(busy == 0, "R8 write outside manual ignored", busy, 0);
    chk(spi_csn == 1, "R8 csn untouched", spi_csn, 1);

    // R8 abort mid-shift
    mon_en = 0;
    half_period = 8'd20;
    send(mk(1, 5'h08, 0), 0);
    send(mk(1, 5'h04, 1), 0);
    repeat (3) @(negedge clk);
    chk(spi_sck == 1, "R8 shift in progress", spi_sck, 1);
    man_en = 0;
    @(negedge clk);
    chk(busy == 0, "R8 busy drops on abort", busy, 0);
    man_en = 1;
    #1;
    chk(spi_csn == 1 && spi_sck == 0, "R8 pins idle after abort", {spi_csn, spi_sck}, 2);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R8 queue flushed", busy, 0);
    prev_csn = spi_csn; prev_sck = spi_sck;
    mon_en = 1;
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 no leftover events", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule